// File: doc/BRIEF.md
# Ping-Pong Buffer Readout Sequencer

This block drains one of two equal buffer regions of a shared synchronous SRAM and hands the bytes to one of two downstream consumers. Firmware or a neighbouring engine issues a one-cycle start pulse with a select bit that picks buffer A or buffer B. The sequencer takes that buffer's byte count from a per-buffer count input and limits it to the buffer size. It then fetches the bytes one at a time through a read port with one cycle of latency and offers each byte on a valid/ready handshake. The bytes go either to the packet-engine sink or to the storage sink, chosen by a direction input that is captured when the transfer starts.

Each buffer has its own completion flag. A start clears the flag of the buffer it names, and the flag sets again when that buffer's readout ends. While one buffer drains, the other can be filled and its count prepared. The caller then alternates starts between the two buffers. Start pulses that arrive during a transfer are dropped.

Top module: `pp_readout_seq`

## Requirements
- R1: After reset the block is idle: busy low, both sink valids low, both completion flags low, and the active-buffer output 0.
- R2: A start with select 0 reads SRAM addresses starting at 0 (buffer A). A start with select 1 reads addresses starting at BUF_BYTES, which is 512 (buffer B). The active-buffer output shows the buffer of the current or most recent start.
- R3: Exactly as many bytes as the selected buffer's count input give are delivered, in ascending address order, each equal to the SRAM content at its address.
- R4: A count greater than BUF_BYTES is treated as BUF_BYTES.
- R5: A start whose count is 0 sets that buffer's completion flag on the next cycle, delivers no bytes, and never raises busy.
- R6: Direction 0 sends the bytes to the packet sink and direction 1 sends them to the storage sink. The direction is sampled with the start, so later changes have no effect on a running transfer.
- R7: A byte offered with valid and not accepted keeps its data stable. The block keeps at most one SRAM read outstanding and moves to the next address only after an acceptance.
- R8: Busy is high for the whole transfer. The completion flag of the active buffer sets, and busy falls, in the cycle after the last byte is accepted.
- R9: An accepted start clears the completion flag of the buffer it selects and leaves the other buffer's flag unchanged.
- R10: A start pulse while busy is ignored: flags, the active buffer and the byte stream do not change.
- R11: At most one of the two sink valid outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start pulse |
| start_sel_i | input | 1 | Buffer select for the start: 0 = A, 1 = B |
| dir_i | input | 1 | Destination: 0 = packet sink, 1 = storage sink |
| count_a_i | input | CNT_W | Byte count for buffer A |
| count_b_i | input | CNT_W | Byte count for buffer B |
| mem_rd_en_o | output | 1 | SRAM read enable |
| mem_addr_o | output | ADDR_W | SRAM read address |
| mem_rd_data_i | input | DATA_W | SRAM read data, one cycle after the enable |
| pkt_valid_o | output | 1 | Packet sink byte valid |
| pkt_data_o | output | DATA_W | Packet sink byte |
| pkt_ready_i | input | 1 | Packet sink ready |
| sto_valid_o | output | 1 | Storage sink byte valid |
| sto_data_o | output | DATA_W | Storage sink byte |
| sto_ready_i | input | 1 | Storage sink ready |
| busy_o | output | 1 | Transfer in progress |
| active_sel_o | output | 1 | Buffer of the current or last start |
| done_a_o | output | 1 | Buffer A completion flag |
| done_b_o | output | 1 | Buffer B completion flag |

## Verification
The checker watches the cycle-level handshake rules on every cycle. These cover one sink valid at a time, data held under backpressure, a single outstanding SRAM read, reads staying inside the active buffer's region, flags rising only when busy is low, and starts during busy leaving state alone. Other properties only show up over a whole transfer, so the bench scenarios must cover them. These are the byte count with clamping, the ascending address order against the memory contents, the exact cycle the flag sets relative to the last acceptance, the zero-count case, and the direction being held while the input toggles.

// File: rtl/pp_readout_pkg.sv
`timescale 1ns/1ps
package pp_readout_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_FETCH   = 2'd1,
      ST_CAPTURE = 2'd2,
      ST_PRESENT = 2'd3
   } rd_state_e;

   localparam int unsigned NUM_BUFS = 2;
endpackage

// File: rtl/pp_len_clamp.sv
`timescale 1ns/1ps
module pp_len_clamp #(
   parameter int unsigned CNT_W     = 10,
   parameter int unsigned BUF_BYTES = 512
) (
   input  logic [CNT_W-1:0] count_a_i,
   input  logic [CNT_W-1:0] count_b_i,
   input  logic             sel_i,
   output logic [CNT_W-1:0] len_o,
   output logic             len_zero_o
);
   localparam logic [CNT_W-1:0] MAX_LEN = CNT_W'(BUF_BYTES);

   logic [CNT_W-1:0] raw;

   always_comb begin
      raw        = sel_i ? count_b_i : count_a_i;
      len_o      = (raw > MAX_LEN) ? MAX_LEN : raw;
      len_zero_o = (raw == '0);
   end
endmodule

// File: rtl/pp_addr_gen.sv
`timescale 1ns/1ps
module pp_addr_gen #(
   parameter int unsigned BUF_BYTES = 512,
   parameter int unsigned CNT_W     = 10,
   localparam int unsigned OFF_W    = $clog2(BUF_BYTES),
   localparam int unsigned ADDR_W   = OFF_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              load_sel_i,
   input  logic [CNT_W-1:0]  load_len_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              sel_o,
   output logic              last_o
);
   logic [OFF_W-1:0] off_q;
   logic [CNT_W-1:0] rem_q;
   logic             sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q <= '0;
         rem_q <= '0;
         sel_q <= 1'b0;
      end else if (load_i) begin
         off_q <= '0;
         rem_q <= load_len_i;
         sel_q <= load_sel_i;
      end else if (step_i) begin
         off_q <= off_q + OFF_W'(1);
         rem_q <= rem_q - CNT_W'(1);
      end
   end

   assign addr_o = {sel_q, off_q};
   assign sel_o  = sel_q;
   assign last_o = (rem_q == CNT_W'(1));
endmodule

// File: rtl/pp_sink_steer.sv
`timescale 1ns/1ps
module pp_sink_steer #(
   parameter int unsigned DATA_W         = 8,
   parameter bit          ZERO_IDLE_DATA = 1'b1
) (
   input  logic              valid_i,
   input  logic              dir_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              pkt_ready_i,
   input  logic              sto_ready_i,
   output logic              pkt_valid_o,
   output logic              sto_valid_o,
   output logic [DATA_W-1:0] pkt_data_o,
   output logic [DATA_W-1:0] sto_data_o,
   output logic              ready_o
);
   assign pkt_valid_o = valid_i & ~dir_i;
   assign sto_valid_o = valid_i &  dir_i;
   assign ready_o     = dir_i ? sto_ready_i : pkt_ready_i;

   generate
      if (ZERO_IDLE_DATA) begin : g_gated
         assign pkt_data_o = pkt_valid_o ? data_i : '0;
         assign sto_data_o = sto_valid_o ? data_i : '0;
      end else begin : g_shared
         assign pkt_data_o = data_i;
         assign sto_data_o = data_i;
      end
   endgenerate
endmodule

// File: rtl/pp_done_flags.sv
`timescale 1ns/1ps
module pp_done_flags #(
   parameter int unsigned NUM = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] clr_i,
   input  logic [NUM-1:0] set_i,
   output logic [NUM-1:0] flag_o
);
   generate
      for (genvar i = 0; i < NUM; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flag_o[i] <= 1'b0;
            else if (set_i[i])  flag_o[i] <= 1'b1;
            else if (clr_i[i])  flag_o[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/pp_readout_seq.sv
`timescale 1ns/1ps
module pp_readout_seq #(
   parameter int unsigned BUF_BYTES      = 512,
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned CNT_W          = 10,
   parameter bit          ZERO_IDLE_DATA = 1'b1,
   localparam int unsigned ADDR_W        = $clog2(BUF_BYTES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              start_sel_i,
   input  logic              dir_i,
   input  logic [CNT_W-1:0]  count_a_i,
   input  logic [CNT_W-1:0]  count_b_i,
   output logic              mem_rd_en_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [DATA_W-1:0] mem_rd_data_i,
   output logic              pkt_valid_o,
   output logic [DATA_W-1:0] pkt_data_o,
   input  logic              pkt_ready_i,
   output logic              sto_valid_o,
   output logic [DATA_W-1:0] sto_data_o,
   input  logic              sto_ready_i,
   output logic              busy_o,
   output logic              active_sel_o,
   output logic              done_a_o,
   output logic              done_b_o
);
   import pp_readout_pkg::*;

   generate
      if ((BUF_BYTES < 2) || ((BUF_BYTES & (BUF_BYTES - 1)) != 0)) begin : g_bad_depth
         $error("BUF_BYTES must be a power of two of at least 2");
      end
      if (CNT_W <= $clog2(BUF_BYTES)) begin : g_bad_cnt
         $error("CNT_W must be able to hold BUF_BYTES");
      end
      if (DATA_W == 0) begin : g_bad_data
         $error("DATA_W must be nonzero");
      end
   endgenerate

   rd_state_e         state_q;
   logic              dir_q;
   logic [DATA_W-1:0] data_q;
   logic [CNT_W-1:0]  len;
   logic              len_zero;
   logic              start_take;
   logic              sink_ready;
   logic              accept;
   logic              last;
   logic              finish;
   logic              zero_hit;
   logic [NUM_BUFS-1:0] flag_clr;
   logic [NUM_BUFS-1:0] flag_set;
   logic [NUM_BUFS-1:0] flags;

   pp_len_clamp #(.CNT_W(CNT_W), .BUF_BYTES(BUF_BYTES)) u_clamp (
      .count_a_i  (count_a_i),
      .count_b_i  (count_b_i),
      .sel_i      (start_sel_i),
      .len_o      (len),
      .len_zero_o (len_zero)
   );

   assign start_take = start_i && (state_q == ST_IDLE);
   assign accept     = (state_q == ST_PRESENT) && sink_ready;

   pp_addr_gen #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (start_take),
      .load_sel_i (start_sel_i),
      .load_len_i (len),
      .step_i     (accept),
      .addr_o     (mem_addr_o),
      .sel_o      (active_sel_o),
      .last_o     (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dir_q   <= 1'b0;
         data_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_take && !len_zero) begin
                  state_q <= ST_FETCH;
                  dir_q   <= dir_i;
               end
            end
            ST_FETCH:   state_q <= ST_CAPTURE;
            ST_CAPTURE: begin
               data_q  <= mem_rd_data_i;
               state_q <= ST_PRESENT;
            end
            ST_PRESENT: begin
               if (sink_ready) state_q <= last ? ST_IDLE : ST_FETCH;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_rd_en_o = (state_q == ST_FETCH);
   assign busy_o      = (state_q != ST_IDLE);

   pp_sink_steer #(.DATA_W(DATA_W), .ZERO_IDLE_DATA(ZERO_IDLE_DATA)) u_steer (
      .valid_i     (state_q == ST_PRESENT),
      .dir_i       (dir_q),
      .data_i      (data_q),
      .pkt_ready_i (pkt_ready_i),
      .sto_ready_i (sto_ready_i),
      .pkt_valid_o (pkt_valid_o),
      .sto_valid_o (sto_valid_o),
      .pkt_data_o  (pkt_data_o),
      .sto_data_o  (sto_data_o),
      .ready_o     (sink_ready)
   );

   assign zero_hit = start_take && len_zero;
   assign finish   = accept && last;
   assign flag_clr = {start_take & start_sel_i, start_take & ~start_sel_i};
   assign flag_set = {(zero_hit & start_sel_i)  | (finish & active_sel_o),
                      (zero_hit & ~start_sel_i) | (finish & ~active_sel_o)};

   pp_done_flags #(.NUM(NUM_BUFS)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (flag_clr),
      .set_i  (flag_set),
      .flag_o (flags)
   );

   assign done_a_o = flags[0];
   assign done_b_o = flags[1];
endmodule

// File: rtl/pp_readout_seq_chk.sv
`timescale 1ns/1ps
module pp_readout_seq_chk #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              mem_rd_en_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              pkt_valid_o,
   input logic [DATA_W-1:0] pkt_data_o,
   input logic              pkt_ready_i,
   input logic              sto_valid_o,
   input logic [DATA_W-1:0] sto_data_o,
   input logic              sto_ready_i,
   input logic              busy_o,
   input logic              active_sel_o,
   input logic              done_a_o,
   input logic              done_b_o
);
   p_one_sink_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pkt_valid_o, sto_valid_o}));

   p_hold_pkt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_data_o)));

   p_hold_sto_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sto_valid_o && !sto_ready_i) |=> (sto_valid_o && $stable(sto_data_o)));

   p_single_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en_o |=> !mem_rd_en_o);

   p_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en_o |-> (mem_addr_o[ADDR_W-1] == active_sel_o));

   p_valid_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid_o || sto_valid_o) |-> busy_o);

   p_flag_a_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_a_o) |-> !busy_o);

   p_flag_b_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_b_o) |-> !busy_o);

   p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !(pkt_valid_o && pkt_ready_i) && !(sto_valid_o && sto_ready_i))
      |=> ($stable(done_a_o) && $stable(done_b_o) && $stable(active_sel_o) && busy_o));
endmodule

bind pp_readout_seq pp_readout_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/pp_readout_seq_tb.sv
`timescale 1ns/1ps
module pp_readout_seq_tb_top;
   localparam int BUF = 512;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       start_sel_i = 1'b0;
   logic       dir_i = 1'b0;
   logic [9:0] count_a_i = '0;
   logic [9:0] count_b_i = '0;
   logic       mem_rd_en_o;
   logic [9:0] mem_addr_o;
   logic [7:0] mem_rd_data_i = '0;
   logic       pkt_valid_o, sto_valid_o;
   logic [7:0] pkt_data_o, sto_data_o;
   logic       pkt_ready_i = 1'b0;
   logic       sto_ready_i = 1'b0;
   logic       busy_o, active_sel_o, done_a_o, done_b_o;

   always #2.5 clk = ~clk;

   pp_readout_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_sel_i(start_sel_i),
      .dir_i(dir_i), .count_a_i(count_a_i), .count_b_i(count_b_i),
      .mem_rd_en_o(mem_rd_en_o), .mem_addr_o(mem_addr_o), .mem_rd_data_i(mem_rd_data_i),
      .pkt_valid_o(pkt_valid_o), .pkt_data_o(pkt_data_o), .pkt_ready_i(pkt_ready_i),
      .sto_valid_o(sto_valid_o), .sto_data_o(sto_data_o), .sto_ready_i(sto_ready_i),
      .busy_o(busy_o), .active_sel_o(active_sel_o), .done_a_o(done_a_o), .done_b_o(done_b_o)
   );

   function automatic logic [7:0] byte_at(input int a);
      return 8'(((a * 37) + (a >> 7)) ^ 8'h5A);
   endfunction

   logic [7:0] mem [0:1023];
   initial for (int i = 0; i < 1024; i++) mem[i] = byte_at(i);
   always @(posedge clk) if (mem_rd_en_o) mem_rd_data_i <= mem[mem_addr_o];

   int n_cmp = 0;
   int n_bad = 0;
   int wd = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", wd, 150000);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
         $finish;
      end
   end

   // vector: {sel, dir, count[9:0], ready_mode[1:0]}
   localparam int NV = 6;
   localparam logic [13:0] VEC [0:NV-1] = '{
      {1'b0, 1'b0, 10'd5,   2'd0},
      {1'b1, 1'b1, 10'd7,   2'd1},
      {1'b0, 1'b1, 10'd1,   2'd2},
      {1'b1, 1'b0, 10'd600, 2'd0},
      {1'b0, 1'b0, 10'd512, 2'd1},
      {1'b1, 1'b1, 10'd3,   2'd0}
   };

   task automatic run_xfer(input bit sel, input bit dir, input int cnt, input int mode, input int poke);
      int  len = (cnt > BUF) ? BUF : cnt;
      int  n_pkt = 0, n_sto = 0, bad = 0, last = -1, done_at = -1;
      bit  other_before = sel ? done_a_o : done_b_o;
      bit  rdy;
      @(negedge clk);
      start_i = 1'b1; start_sel_i = sel; dir_i = dir;
      if (sel) count_b_i = 10'(cnt); else count_a_i = 10'(cnt);
      for (int k = 1; k < 6000; k++) begin
         @(negedge clk);
         start_i     = (k == poke);
         start_sel_i = (k == poke) ? ~sel : sel;
         dir_i       = ~dir;                        // R6: must not redirect
         rdy = (mode == 0) ? 1'b1 : (mode == 1) ? k[0] : ((k % 3) == 0);
         pkt_ready_i = rdy; sto_ready_i = rdy;
         if (k == 1) begin
            chk((sel ? done_b_o : done_a_o) == 1'b0, "R9", "own flag cleared by start",
                sel ? done_b_o : done_a_o, 0);
            chk(busy_o == 1'b1, "R8", "busy after start", busy_o, 1);
         end
         if (!busy_o) begin done_at = k; break; end
         if (pkt_valid_o && pkt_ready_i) begin
            if (pkt_data_o != byte_at((sel ? BUF : 0) + n_pkt + n_sto)) bad++;
            n_pkt++; last = k;
         end
         if (sto_valid_o && sto_ready_i) begin
            if (sto_data_o != byte_at((sel ? BUF : 0) + n_pkt + n_sto)) bad++;
            n_sto++; last = k;
         end
      end
      pkt_ready_i = 1'b0; sto_ready_i = 1'b0; start_i = 1'b0;
      chk((dir ? n_sto : n_pkt) == len, cnt > BUF ? "R4" : "R3", "bytes on chosen sink",
          dir ? n_sto : n_pkt, len);
      chk((dir ? n_pkt : n_sto) == 0, "R6", "bytes on other sink", dir ? n_pkt : n_sto, 0);
      chk(bad == 0, "R3", "data order mismatches", bad, 0);
      chk(done_at == last + 1, "R8", "flag cycle vs last accept", done_at, last + 1);
      chk((sel ? done_b_o : done_a_o) == 1'b1, "R8", "own flag set", sel ? done_b_o : done_a_o, 1);
      chk((sel ? done_a_o : done_b_o) == other_before, "R9", "other flag unchanged",
          sel ? done_a_o : done_b_o, other_before);
      chk(active_sel_o == sel, "R2", "active buffer", active_sel_o, sel);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy_o == 0, "R1", "busy in reset", busy_o, 0);
      chk(!pkt_valid_o && !sto_valid_o, "R1", "valids in reset", pkt_valid_o | sto_valid_o, 0);
      chk(!done_a_o && !done_b_o, "R1", "flags in reset", {done_a_o, done_b_o}, 0);
      chk(active_sel_o == 0, "R1", "active buffer in reset", active_sel_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 zero count on buffer A
      start_i = 1'b1; start_sel_i = 1'b0; count_a_i = 10'd0;
      @(negedge clk);
      start_i = 1'b0; pkt_ready_i = 1'b1; sto_ready_i = 1'b1;
      chk(done_a_o == 1, "R5", "zero count flag", done_a_o, 1);
      chk(busy_o == 0, "R5", "zero count busy", busy_o, 0);
      chk(done_b_o == 0, "R9", "zero count other flag", done_b_o, 0);
      begin
         int seen = 0;
         for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (pkt_valid_o || sto_valid_o || busy_o) seen++;
         end
         chk(seen == 0, "R5", "zero count activity", seen, 0);
      end
      pkt_ready_i = 1'b0; sto_ready_i = 1'b0;

      // table of vectors (R2, R3, R4, R6, R7, R8, R9)
      for (int v = 0; v < NV; v++)
         run_xfer(VEC[v][13], VEC[v][12], int'(VEC[v][11:2]), int'(VEC[v][1:0]), -1);

      // R10: start on A while B is busy, under backpressure (R7)
      count_a_i = 10'd9;
      run_xfer(1'b1, 1'b1, 4, 2, 3);
      chk(done_a_o == 1, "R10", "flag A after ignored start", done_a_o, 1);

      // R10: start on B while A is busy
      count_b_i = 10'd0;
      run_xfer(1'b0, 1'b0, 6, 1, 2);

      repeat (2) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule